// File: doc/BRIEF.md
# Integer Add and Legacy Arithmetic Unit

This block is the integer add path of an execution pipeline. Each cycle it accepts one operation code with two 32-bit register values, a 16-bit signed immediate, a flag telling it that the first source field names the hard-wired zero register, and the current carry, overflow and summary-overflow bits. It covers the add family: plain, carrying, extended, the three immediate forms, add-to-minus-one and add-to-zero. It also covers two older operations: absolute value and difference-or-zero, both in register and immediate form.

The results are registered. One clock after issue the block presents the 32-bit result and the next values of the carry, overflow and summary-overflow bits. When the operation records, it also presents a 4-bit condition field with a write strobe. A single shared adder serves every operation. The operand selector feeds it inverted, constant or immediate inputs so that each variant is a plain sum.

Top module: `int_add_unit`

## Requirements
- R1: Code 0 (add) returns ra+rb and passes the carry-in to the carry output unchanged.
- R2: Code 1 (add carrying) returns ra+rb and drives the carry output with the carry-out of bit 31.
- R3: Code 2 (add extended) returns ra+rb+carry-in and drives the carry output with the new carry-out.
- R4: Code 7 (add to minus one) returns ra+carry-in+0xFFFFFFFF and code 8 (add to zero) returns ra+carry-in. Both drive the carry output with the carry-out.
- R5: Codes 3, 4 and 6 (add immediate, add immediate carrying, add immediate shifted) add the sign-extended immediate, or for code 6 the immediate shifted left by 16. The first operand is taken as 0 when the zero-register flag is set. Code 4 writes the carry-out, while codes 3 and 6 pass the carry through.
- R6: Code 5 (add immediate carrying, recording) behaves as code 4 and always writes the condition field, whatever the record-enable input says.
- R7: Code 9 (absolute value) returns |ra| and leaves the carry unchanged. For ra = 0x80000000 it returns 0x80000000 and reports overflow when overflow is enabled.
- R8: Code 10 (difference or zero) returns 0 when ra > rb as signed values, else rb-ra. Code 11 does the same with the sign-extended immediate in place of rb. Both leave the carry unchanged and report overflow of rb-ra.
- R9: For codes 0, 1, 2, 7, 8, 9 and 10 with overflow enabled, the overflow output is the signed overflow of the operation and the summary-overflow output is summary-in OR overflow. In every other case both outputs equal their inputs.
- R10: When recording, the write strobe is high and the field is bit 3 negative, bit 2 positive, bit 1 zero (result as signed against 0), bit 0 the final summary-overflow. Codes 0, 1, 2, 7, 8, 9 and 10 record when record-enable is high. When not recording, the strobe and the field are 0.
- R11: The outputs show the operation issued at the previous rising clock edge. A rising edge with rst_n low clears the result, all flag outputs, the field and the strobe.
- R12: Codes 12 to 15 return result 0, pass carry, overflow and summary-overflow through unchanged, and do not record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 4 | Operation select |
| ra_val | input | 32 | First source register value |
| rb_val | input | 32 | Second source register value |
| ra_is_zero | input | 1 | First source field names the zero register |
| imm16 | input | 16 | Signed immediate |
| ca_in | input | 1 | Current carry bit |
| ov_in | input | 1 | Current overflow bit |
| so_in | input | 1 | Current summary-overflow bit |
| ov_en | input | 1 | Overflow reporting enable |
| rec_en | input | 1 | Record condition field enable |
| res_out | output | 32 | Result |
| ca_out | output | 1 | Next carry bit |
| ov_out | output | 1 | Next overflow bit |
| so_out | output | 1 | Next summary-overflow bit |
| cr_wr | output | 1 | Condition field write strobe |
| cr_out | output | 4 | Condition field |

## Verification
The hardest cases are the ones where two rules interact in one operation. One is difference-or-zero with the most negative first operand, where the signed compare and the overflow rule meet. Another is the recording immediate form, where the field is written although record-enable is low. A third is summary-overflow already set when an operation clears overflow. The stimulus table places each of these on its own row with the flag inputs preset to the value the block must not disturb. Separate rows check that an operation without overflow reporting passes through an overflow input of 1 unchanged.

// File: rtl/aiu_pkg.sv
// Shared operation codes and classification helpers for the integer add unit.
// Assumes a 4-bit operation code; codes above OP_DOZI are undefined.
package aiu_pkg;

    localparam int OP_W = 4;
    localparam int CR_W = 4;

    // Bit positions inside the condition field
    localparam int CR_NEG  = 3;
    localparam int CR_POS  = 2;
    localparam int CR_ZERO = 1;
    localparam int CR_SUM  = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD      = 4'd0,
        OP_ADDC     = 4'd1,
        OP_ADDE     = 4'd2,
        OP_ADDI     = 4'd3,
        OP_ADDIC    = 4'd4,
        OP_ADDICR   = 4'd5,
        OP_ADDIS    = 4'd6,
        OP_ADDME    = 4'd7,
        OP_ADDZE    = 4'd8,
        OP_ABS      = 4'd9,
        OP_DOZ      = 4'd10,
        OP_DOZI     = 4'd11
    } aiu_op_e;

    // True for a defined operation code
    function automatic logic op_known(input logic [OP_W-1:0] op);
        return op <= OP_DOZI;
    endfunction

    // True for forms that honour overflow-enable and record-enable
    function automatic logic op_has_oe_rc(input logic [OP_W-1:0] op);
        return (op == OP_ADD)   || (op == OP_ADDC)  || (op == OP_ADDE) ||
               (op == OP_ADDME) || (op == OP_ADDZE) || (op == OP_ABS)  ||
               (op == OP_DOZ);
    endfunction

    // True for forms that write the carry bit
    function automatic logic op_writes_ca(input logic [OP_W-1:0] op);
        return (op == OP_ADDC)  || (op == OP_ADDE)  || (op == OP_ADDIC) ||
               (op == OP_ADDICR)|| (op == OP_ADDME) || (op == OP_ADDZE);
    endfunction

    // True for immediate add forms that read the zero register as 0
    function automatic logic op_zero_ra(input logic [OP_W-1:0] op);
        return (op == OP_ADDI) || (op == OP_ADDIC) ||
               (op == OP_ADDICR) || (op == OP_ADDIS);
    endfunction

endpackage

// File: rtl/aiu_operand_sel.sv
// Operand selector: maps every operation onto one sum a + b + cin.
// Assumes DATA_W >= 2*IMM_W is not required; the shifted immediate is
// truncated to DATA_W. Purely combinational.
module aiu_operand_sel
    import aiu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] ra,
    input  logic [DATA_W-1:0] rb,
    input  logic              ra_zero,
    input  logic [IMM_W-1:0]  imm,
    input  logic              ca_in,
    output logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] opb,
    output logic              cin,
    output logic [DATA_W-1:0] imm_ext
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_shl;
    logic [DATA_W-1:0] ra_eff;

    // Sign extension and left shift of the immediate
    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        imm_shl = DATA_W'(imm) << IMM_W;
    end

    // Zero-register substitution for immediate add forms
    always_comb begin
        ra_eff = (op_zero_ra(op) && ra_zero) ? '0 : ra;
    end

    // Per-operation adder inputs
    always_comb begin
        opa = '0;
        opb = '0;
        cin = 1'b0;
        case (op)
            OP_ADD, OP_ADDC: begin
                opa = ra;
                opb = rb;
            end
            OP_ADDE: begin
                opa = ra;
                opb = rb;
                cin = ca_in;
            end
            OP_ADDI, OP_ADDIC, OP_ADDICR: begin
                opa = ra_eff;
                opb = imm_ext;
            end
            OP_ADDIS: begin
                opa = ra_eff;
                opb = imm_shl;
            end
            OP_ADDME: begin
                opa = ra;
                opb = '1;
                cin = ca_in;
            end
            OP_ADDZE: begin
                opa = ra;
                cin = ca_in;
            end
            OP_ABS: begin
                opa = ra[DATA_W-1] ? ~ra : ra;
                cin = ra[DATA_W-1];
            end
            OP_DOZ: begin
                opa = ~ra;
                opb = rb;
                cin = 1'b1;
            end
            OP_DOZI: begin
                opa = ~ra;
                opb = imm_ext;
                cin = 1'b1;
            end
            default: begin
                opa = '0;
                opb = '0;
                cin = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/aiu_adder.sv
// Shared adder: sum with carry-in, carry-out and signed overflow.
// Overflow uses the sign rule on the final sum, which stays correct with
// a carry-in of one. Purely combinational.
module aiu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    // Full-width add with carry
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end

    // Signed overflow from operand and sum signs
    always_comb begin
        ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    end

endmodule

// File: rtl/aiu_flag_unit.sv
// Flag and condition-field logic: decides which flags an operation writes
// and builds the condition field. Assumes the result given is already
// final (zeroed for difference-or-zero and undefined codes).
module aiu_flag_unit
    import aiu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] res,
    input  logic              cout,
    input  logic              ovf,
    input  logic              ca_in,
    input  logic              ov_in,
    input  logic              so_in,
    input  logic              ov_en,
    input  logic              rec_en,
    output logic              ca_nx,
    output logic              ov_nx,
    output logic              so_nx,
    output logic              cr_wr_nx,
    output logic [CR_W-1:0]   cr_nx
);

    logic oe_active;

    // Carry update for carry-writing forms only
    always_comb begin
        ca_nx = op_writes_ca(op) ? cout : ca_in;
    end

    // Overflow and sticky summary update when reporting is enabled
    always_comb begin
        oe_active = op_has_oe_rc(op) && ov_en;
        ov_nx     = oe_active ? ovf : ov_in;
        so_nx     = oe_active ? (so_in | ovf) : so_in;
    end

    // Condition field from the signed result and final summary bit
    always_comb begin
        cr_wr_nx = (op == OP_ADDICR) || (op_has_oe_rc(op) && rec_en);
        cr_nx    = '0;
        if (cr_wr_nx) begin
            cr_nx[CR_NEG]  = res[DATA_W-1];
            cr_nx[CR_POS]  = !res[DATA_W-1] && (res != '0);
            cr_nx[CR_ZERO] = (res == '0);
            cr_nx[CR_SUM]  = so_nx;
        end
    end

endmodule

// File: rtl/int_add_unit.sv
// Integer add and legacy arithmetic unit, one registered stage.
// Issues one operation per cycle; outputs reflect the operation sampled
// at the previous rising edge. Synchronous active-low reset clears outputs.
module int_add_unit
    import aiu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] ra_val,
    input  logic [DATA_W-1:0] rb_val,
    input  logic              ra_is_zero,
    input  logic [IMM_W-1:0]  imm16,
    input  logic              ca_in,
    input  logic              ov_in,
    input  logic              so_in,
    input  logic              ov_en,
    input  logic              rec_en,
    output logic [DATA_W-1:0] res_out,
    output logic              ca_out,
    output logic              ov_out,
    output logic              so_out,
    output logic              cr_wr,
    output logic [3:0]        cr_out
);

    logic [DATA_W-1:0] opa, opb, imm_ext, sum, res_nx;
    logic              cin, cout, ovf, ovf_eff;
    logic              doz_zero;
    logic              ca_nx, ov_nx, so_nx, cr_wr_nx;
    logic [CR_W-1:0]   cr_nx;

    aiu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .op      (op_code),
        .ra      (ra_val),
        .rb      (rb_val),
        .ra_zero (ra_is_zero),
        .imm     (imm16),
        .ca_in   (ca_in),
        .opa     (opa),
        .opb     (opb),
        .cin     (cin),
        .imm_ext (imm_ext)
    );

    aiu_adder #(.W(DATA_W)) u_add (
        .a    (opa),
        .b    (opb),
        .cin  (cin),
        .sum  (sum),
        .cout (cout),
        .ovf  (ovf)
    );

    // Signed compare selecting the zero outcome of difference-or-zero
    always_comb begin
        case (op_code)
            OP_DOZ:  doz_zero = $signed(ra_val) > $signed(rb_val);
            OP_DOZI: doz_zero = $signed(ra_val) > $signed(imm_ext);
            default: doz_zero = 1'b0;
        endcase
    end

    // Final result and overflow after zeroing cases
    always_comb begin
        if (!op_known(op_code) || doz_zero) begin
            res_nx  = '0;
            ovf_eff = 1'b0;
        end else begin
            res_nx  = sum;
            ovf_eff = ovf;
        end
    end

    aiu_flag_unit #(.DATA_W(DATA_W)) u_flags (
        .op       (op_code),
        .res      (res_nx),
        .cout     (cout),
        .ovf      (ovf_eff),
        .ca_in    (ca_in),
        .ov_in    (ov_in),
        .so_in    (so_in),
        .ov_en    (ov_en),
        .rec_en   (rec_en),
        .ca_nx    (ca_nx),
        .ov_nx    (ov_nx),
        .so_nx    (so_nx),
        .cr_wr_nx (cr_wr_nx),
        .cr_nx    (cr_nx)
    );

    // Output register stage with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out <= '0;
            ca_out  <= 1'b0;
            ov_out  <= 1'b0;
            so_out  <= 1'b0;
            cr_wr   <= 1'b0;
            cr_out  <= '0;
        end else begin
            res_out <= res_nx;
            ca_out  <= ca_nx;
            ov_out  <= ov_nx;
            so_out  <= so_nx;
            cr_wr   <= cr_wr_nx;
            cr_out  <= cr_nx;
        end
    end

endmodule

// File: rtl/aiu_checker.sv
// Property checker for int_add_unit, attached by bind. Relates the
// registered outputs to the inputs sampled one edge earlier.
module aiu_checker
    import aiu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_code,
    input logic [DATA_W-1:0] ra_val,
    input logic [DATA_W-1:0] rb_val,
    input logic              ca_in,
    input logic              ov_in,
    input logic              so_in,
    input logic              ov_en,
    input logic [DATA_W-1:0] res_out,
    input logic              ca_out,
    input logic              ov_out,
    input logic              so_out,
    input logic              cr_wr,
    input logic [3:0]        cr_out
);

    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic past_ok;
    logic started;

    // Marks that the previous edge ran out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Marks that at least one edge has occurred
    always_ff @(posedge clk) begin
        started <= 1'b1;
    end

    assert_ca_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(op_code) == OP_ADD) |-> ca_out == $past(ca_in));

    assert_abs_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(op_code) == OP_ABS) && ($past(ra_val) == MIN_NEG)
        |-> res_out == MIN_NEG);

    assert_doz_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(op_code) == OP_DOZ) &&
        ($signed($past(ra_val)) > $signed($past(rb_val))) |-> res_out == '0);

    assert_ov_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(ov_en) |-> (ov_out == $past(ov_in)) && (so_out == $past(so_in)));

    assert_so_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(so_in) |-> so_out);

    assert_cr_form_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cr_wr |-> ($countones(cr_out[3:1]) == 1) && (cr_out[0] == so_out));

    assert_cr_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cr_wr |-> cr_out == 4'd0);

    assert_reset_clear_R11: assert property (@(posedge clk)
        started && rst_n && $past(!rst_n) |-> (res_out == '0) && !cr_wr && !ca_out);

    assert_undef_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(op_code) > OP_DOZI) |-> (res_out == '0) && !cr_wr);

endmodule

bind int_add_unit aiu_checker #(.DATA_W(DATA_W)) u_aiu_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_code (op_code),
    .ra_val  (ra_val),
    .rb_val  (rb_val),
    .ca_in   (ca_in),
    .ov_in   (ov_in),
    .so_in   (so_in),
    .ov_en   (ov_en),
    .res_out (res_out),
    .ca_out  (ca_out),
    .ov_out  (ov_out),
    .so_out  (so_out),
    .cr_wr   (cr_wr),
    .cr_out  (cr_out)
);

// File: tb/int_add_unit_bench.sv
// Table-driven bench for int_add_unit followed by directed reset and
// latency tests. Inputs change on the falling edge; outputs are sampled
// on the falling edge after the rising edge that registers them.
module int_add_unit_bench;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] ra;
        logic [31:0] rb;
        logic        raz;
        logic [15:0] imm;
        logic        ca;
        logic        ov;
        logic        so;
        logic        oen;
        logic        rec;
        logic [31:0] eres;
        logic        eca;
        logic        eov;
        logic        eso;
        logic        ecrw;
        logic [3:0]  ecr;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        // op   ra            rb            raz imm      ca   ov   so   oen  rec  eres          eca  eov  eso  ecrw ecr      req
        '{4'd0, 32'h00000001, 32'h00000002, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000003, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd1},  // R1
        '{4'd0, 32'h7FFFFFFF, 32'h00000001, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h80000000, 1'b0, 1'b1, 1'b1, 1'b1, 4'b1001, 8'd9},  // R9 R10
        '{4'd1, 32'hFFFFFFFF, 32'h00000001, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0010, 8'd2},  // R2
        '{4'd1, 32'h00000001, 32'h00000001, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000002, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd2},  // R2
        '{4'd2, 32'hFFFFFFFF, 32'h00000000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd3},  // R3
        '{4'd2, 32'h00000005, 32'h00000006, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000000C, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd3},  // R3
        '{4'd7, 32'h00000000, 32'h00000000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1000, 8'd4},  // R4
        '{4'd7, 32'h00000005, 32'h00000000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000005, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd4},  // R4
        '{4'd8, 32'hFFFFFFFF, 32'h00000000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd4},  // R4
        '{4'd3, 32'h00000100, 32'h00000000, 1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h000000FF, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd5},  // R5
        '{4'd3, 32'h00000100, 32'h00000000, 1'b1, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF8000, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd5},  // R5
        '{4'd6, 32'h00000001, 32'h00000000, 1'b0, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00020001, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd5},  // R5
        '{4'd4, 32'hFFFFFFFF, 32'h00000000, 1'b0, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd5},  // R5
        '{4'd5, 32'h00000003, 32'h00000000, 1'b0, 16'hFFFE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000001, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0100, 8'd6},  // R6
        '{4'd9, 32'hFFFFFFFB, 32'h00000000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h00000005, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd7},  // R7
        '{4'd9, 32'h80000000, 32'h00000000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h80000000, 1'b0, 1'b1, 1'b1, 1'b1, 4'b1001, 8'd7},  // R7
        '{4'd10,32'h00000005, 32'h00000003, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h00000000, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0010, 8'd8},  // R8
        '{4'd10,32'h00000003, 32'h0000000A, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000007, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd8},  // R8
        '{4'd10,32'hFFFFFFFF, 32'h00000001, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000002, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd8},  // R8
        '{4'd11,32'h00000002, 32'h00000000, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd8},  // R8
        '{4'd11,32'hFFFFFFFE, 32'h00000000, 1'b0, 16'h0005, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000007, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd8},  // R8
        '{4'd10,32'h80000000, 32'h7FFFFFFF, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000, 8'd8},  // R8 R9
        '{4'd0, 32'h7FFFFFFF, 32'h00000001, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h80000000, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000, 8'd9},  // R9
        '{4'd3, 32'h7FFFFFFF, 32'h00000000, 1'b0, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h80000000, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 8'd9},  // R9 R10
        '{4'd0, 32'h00000001, 32'h00000001, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h00000002, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0000, 8'd9},  // R9
        '{4'd15,32'h00000005, 32'h00000001, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h00000000, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, 8'd12}  // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] ra_val = '0;
    logic [31:0] rb_val = '0;
    logic        ra_is_zero = 1'b0;
    logic [15:0] imm16 = '0;
    logic        ca_in = 1'b0;
    logic        ov_in = 1'b0;
    logic        so_in = 1'b0;
    logic        ov_en = 1'b0;
    logic        rec_en = 1'b0;
    logic [31:0] res_out;
    logic        ca_out, ov_out, so_out, cr_wr;
    logic [3:0]  cr_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int_add_unit u_int_add_unit (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .ra_val(ra_val),
        .rb_val(rb_val), .ra_is_zero(ra_is_zero), .imm16(imm16),
        .ca_in(ca_in), .ov_in(ov_in), .so_in(so_in), .ov_en(ov_en),
        .rec_en(rec_en), .res_out(res_out), .ca_out(ca_out),
        .ov_out(ov_out), .so_out(so_out), .cr_wr(cr_wr), .cr_out(cr_out)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    // Compare one value and count the outcome
    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one table row
    task automatic apply(input vec_t v);
        op_code = v.op; ra_val = v.ra; rb_val = v.rb; ra_is_zero = v.raz;
        imm16 = v.imm; ca_in = v.ca; ov_in = v.ov; so_in = v.so;
        ov_en = v.oen; rec_en = v.rec;
    endtask

    // Hang guard
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R11: reset with live inputs clears every output
        apply(VECS[1]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", "reset res", res_out, 32'h0);
        check("R11", "reset flags", {28'h0, ca_out, ov_out, so_out, cr_wr}, 32'h0);
        check("R11", "reset cr", {28'h0, cr_out}, 32'h0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d row%0d", VECS[i].req, i);
            apply(VECS[i]);
            @(posedge clk);
            @(negedge clk);
            check(tag, "res", res_out, VECS[i].eres);
            check(tag, "ca", {31'h0, ca_out}, {31'h0, VECS[i].eca});
            check(tag, "ov", {31'h0, ov_out}, {31'h0, VECS[i].eov});
            check(tag, "so", {31'h0, so_out}, {31'h0, VECS[i].eso});
            check(tag, "cr_wr", {31'h0, cr_wr}, {31'h0, VECS[i].ecrw});
            check(tag, "cr", {28'h0, cr_out}, {28'h0, VECS[i].ecr});
        end

        // R11: output holds until the next rising edge, then updates
        op_code = 4'd0; ra_val = 32'd10; rb_val = 32'd20; ov_en = 1'b0;
        rec_en = 1'b0; ca_in = 1'b0; ov_in = 1'b0; so_in = 1'b0;
        #2;
        check("R11", "before edge", res_out, 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R11", "after edge", res_out, 32'd30);

        // R5: zero-register flag ignored by register form add
        ra_is_zero = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R5", "raz on add", res_out, 32'd30);
        ra_is_zero = 1'b0;

        // R11: reset in mid stream clears outputs
        op_code = 4'd5; ra_val = 32'd1; imm16 = 16'd1; ca_in = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R11", "mid reset res", res_out, 32'h0);
        check("R11", "mid reset strobe", {31'h0, cr_wr}, 32'h0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R6", "after reset", {cr_wr, cr_out, res_out[26:0]}, {1'b1, 4'b0100, 27'd2});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule